// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches a received serial line one bit at a time and keeps a loss-of-signal alarm. A bit is taken only on a clock cycle where the bit-enable input is high. This lets the block run directly on a recovered bit clock with a valid qualifier, or on a faster system clock with an enable strobe. A mark is a 1 on the data input and a space is a 0. One mode input picks between two rule sets.

The DS3 rule set, selected with the mode input at 0, raises the alarm after a long unbroken run of spaces. It drops the alarm once the mark density over a sliding window of recent bits reaches a threshold. The E3 rule set, selected with the mode input at 1, raises the alarm after a shorter run of spaces. It drops the alarm once a full run of bits has arrived that holds no group of four zeros in a row. Next to the level alarm, the block gives a one-clock pulse when the alarm is raised and another when it is dropped, for an interrupt or event collector downstream.

Top module: `los_monitor`

## Requirements
- R1: While synchronous reset is high and on the first clock after it, `los_alarm`, `los_declared` and `los_cleared` are all 0. Reset empties every counter and clears the bit history.
- R2: With `mode_e3` = 0, the alarm rises on the enabled bit that completes 180 consecutive spaces. A run of 179 spaces does not raise it.
- R3: With `mode_e3` = 0 and the alarm high, the alarm falls on the enabled bit that brings the number of marks among the last 180 enabled bits to 60. A count of 59 does not clear it.
- R4: With `mode_e3` = 1, the alarm rises on the enabled bit that completes 32 consecutive spaces. A run of 31 spaces does not raise it.
- R5: With `mode_e3` = 1 and the alarm high, the alarm falls on the enabled bit that completes 32 consecutive bits with no four consecutive zeros. Each fourth consecutive zero restarts that count from zero.
- R6: `los_declared` is high for exactly the one clock in which `los_alarm` first reads 1, and at no other time.
- R7: `los_cleared` is high for exactly the one clock in which `los_alarm` first reads 0 after a detected recovery, and at no other time.
- R8: On a cycle with `bit_en` = 0, the data input is ignored. No counter, window content or alarm output changes.
- R9: A change of `mode_e3` drops the alarm to 0 on the next clock without a `los_cleared` pulse. It empties all counters and the window, and the bit sampled on that change cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock or system clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `rx_bit` as a line bit on this cycle |
| rx_bit | input | 1 | Received line bit, 1 = mark, 0 = space |
| mode_e3 | input | 1 | Rule set: 0 = DS3, 1 = E3 |
| los_alarm | output | 1 | Loss-of-signal level |
| los_declared | output | 1 | One-clock pulse when the alarm is raised |
| los_cleared | output | 1 | One-clock pulse when the alarm is dropped |

## Verification
All three outputs are registered. A bit that completes a raise or clear condition on clock edge N shows on `los_alarm` and on the matching pulse right after edge N. The pulse is gone after edge N+1. A mode change seen at edge N forces the alarm low right after edge N. The bench drives each input at a falling edge and samples 1 ns after the next rising edge. It compares all three outputs against its own bit-level model on every cycle, so every one-edge latency and every pulse width is checked in the cycle it falls due.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int DS3_WIN_BITS   = 180;
    localparam int DS3_CLR_MARKS  = 60;
    localparam int E3_RUN_BITS    = 32;
    localparam int E3_ZERO_LIMIT  = 4;

    typedef enum logic {
        LOS_MODE_DS3 = 1'b0,
        LOS_MODE_E3  = 1'b1
    } los_mode_e;

    typedef struct packed {
        logic declare;
        logic clear;
    } los_evt_t;

    function automatic int cnt_width(input int max_val);
        return $clog2(max_val + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/los_ds3_window.sv
module los_ds3_window #(
    parameter int WIN = 180,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          adv,
    input  logic          bit_i,
    output logic [CW-1:0] cnt_nxt
);
    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  cnt_q;

    // Running mark count: add the arriving bit, drop the oldest one.
    always_comb begin
        cnt_nxt = cnt_q + CW'(bit_i) - CW'(hist_q[WIN-1]);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[WIN-2:0], bit_i};
            cnt_q  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/los_run_track.sv
module los_run_track #(
    parameter int ZSAT = 180,
    parameter int ZLIM = 4,
    parameter int RUN  = 32,
    parameter int ZW   = 8,
    parameter int RW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          adv,
    input  logic          bit_i,
    output logic [ZW-1:0] zrun_nxt,
    output logic [RW-1:0] crun_nxt
);
    logic [ZW-1:0] zrun_q;
    logic [RW-1:0] crun_q;

    always_comb begin
        if (bit_i)
            zrun_nxt = '0;
        else if (zrun_q == ZW'(ZSAT))
            zrun_nxt = zrun_q;
        else
            zrun_nxt = zrun_q + 1'b1;

        // A fourth zero in a row voids the clean run built so far.
        if (zrun_nxt >= ZW'(ZLIM))
            crun_nxt = '0;
        else if (crun_q == RW'(RUN))
            crun_nxt = crun_q;
        else
            crun_nxt = crun_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            zrun_q <= '0;
            crun_q <= '0;
        end else if (adv) begin
            zrun_q <= zrun_nxt;
            crun_q <= crun_nxt;
        end
    end
endmodule

// File: rtl/los_alarm_ctl.sv
module los_alarm_ctl
    import los_pkg::*;
#(
    parameter int DS3_WIN   = 180,
    parameter int DS3_MARKS = 60,
    parameter int E3_RUN    = 32,
    parameter int CW        = 8,
    parameter int ZW        = 8,
    parameter int RW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          adv,
    input  los_mode_e     mode,
    input  logic [ZW-1:0] zrun_nxt,
    input  logic [RW-1:0] crun_nxt,
    input  logic [CW-1:0] cnt_nxt,
    output logic          alarm,
    output logic          declared,
    output logic          cleared
);
    los_evt_t evt;
    logic     raise_hit;
    logic     drop_hit;

    always_comb begin
        if (mode == LOS_MODE_E3) begin
            raise_hit = (zrun_nxt >= ZW'(E3_RUN));
            drop_hit  = (crun_nxt >= RW'(E3_RUN));
        end else begin
            raise_hit = (zrun_nxt >= ZW'(DS3_WIN));
            drop_hit  = (cnt_nxt  >= CW'(DS3_MARKS));
        end
        evt.declare = adv && !flush && !alarm && raise_hit;
        evt.clear   = adv && !flush &&  alarm && drop_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            alarm    <= 1'b0;
            declared <= 1'b0;
            cleared  <= 1'b0;
        end else begin
            declared <= evt.declare;
            cleared  <= evt.clear;
            if (evt.declare)
                alarm <= 1'b1;
            else if (evt.clear)
                alarm <= 1'b0;
        end
    end
endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int DS3_WIN   = los_pkg::DS3_WIN_BITS,
    parameter int DS3_MARKS = los_pkg::DS3_CLR_MARKS,
    parameter int E3_RUN    = los_pkg::E3_RUN_BITS,
    parameter int E3_ZLIM   = los_pkg::E3_ZERO_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic mode_e3,
    output logic los_alarm,
    output logic los_declared,
    output logic los_cleared
);
    localparam int ZSAT = max_of(DS3_WIN, E3_RUN);
    localparam int CW   = cnt_width(DS3_WIN);
    localparam int ZW   = cnt_width(ZSAT);
    localparam int RW   = cnt_width(E3_RUN);

    los_mode_e     mode_cur;
    los_mode_e     mode_q;
    logic          flush;
    logic [CW-1:0] cnt_nxt;
    logic [ZW-1:0] zrun_nxt;
    logic [RW-1:0] crun_nxt;

    assign mode_cur = los_mode_e'(mode_e3);
    assign flush    = (mode_cur != mode_q);

    always_ff @(posedge clk) begin
        mode_q <= mode_cur;
    end

    los_ds3_window #(.WIN(DS3_WIN), .CW(CW)) u_window (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .adv     (bit_en),
        .bit_i   (rx_bit),
        .cnt_nxt (cnt_nxt)
    );

    los_run_track #(
        .ZSAT (ZSAT),
        .ZLIM (E3_ZLIM),
        .RUN  (E3_RUN),
        .ZW   (ZW),
        .RW   (RW)
    ) u_runs (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .adv      (bit_en),
        .bit_i    (rx_bit),
        .zrun_nxt (zrun_nxt),
        .crun_nxt (crun_nxt)
    );

    los_alarm_ctl #(
        .DS3_WIN   (DS3_WIN),
        .DS3_MARKS (DS3_MARKS),
        .E3_RUN    (E3_RUN),
        .CW        (CW),
        .ZW        (ZW),
        .RW        (RW)
    ) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .adv      (bit_en),
        .mode     (mode_cur),
        .zrun_nxt (zrun_nxt),
        .crun_nxt (crun_nxt),
        .cnt_nxt  (cnt_nxt),
        .alarm    (los_alarm),
        .declared (los_declared),
        .cleared  (los_cleared)
    );
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic rx_bit,
    input logic mode_e3,
    input logic los_alarm,
    input logic los_declared,
    input logic los_cleared
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!los_alarm && !los_declared && !los_cleared));

    // R6
    rise_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(los_alarm) |-> los_declared);

    // R6
    declare_needs_space_chk: assert property (@(posedge clk) disable iff (rst)
        los_declared |-> (los_alarm && $past(bit_en) && !$past(rx_bit)));

    // R7
    cleared_after_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        los_cleared |-> (!los_alarm && $past(los_alarm) && $past(bit_en)));

    // R7
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(los_declared && los_cleared));

    // R8
    idle_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && $stable(mode_e3)) |=> ($stable(los_alarm) && !los_declared && !los_cleared));

    // R9
    mode_switch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_e3) |=> (!los_alarm && !los_cleared && !los_declared));
endmodule

bind los_monitor los_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .rx_bit       (rx_bit),
    .mode_e3      (mode_e3),
    .los_alarm    (los_alarm),
    .los_declared (los_declared),
    .los_cleared  (los_cleared)
);

// File: tb/los_monitor_tb.sv
`timescale 1ns/1ps
module los_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic rx_bit = 1'b0;
    logic mode_e3 = 1'b0;
    logic los_alarm, los_declared, los_cleared;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    bit hist [180];
    int ptr = 0;
    int m_cnt = 0;
    int m_zr = 0;
    int m_cr = 0;
    bit m_alarm = 1'b0;
    bit m_decl = 1'b0;
    bit m_clr = 1'b0;
    bit m_mode = 1'b0;

    always #2 clk = ~clk;

    los_monitor u_dut (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .mode_e3      (mode_e3),
        .los_alarm    (los_alarm),
        .los_declared (los_declared),
        .los_cleared  (los_cleared)
    );

    function automatic bit raise_rule(input bit m, input int zr);
        return m ? (zr >= 32) : (zr >= 180);
    endfunction

    function automatic bit drop_rule(input bit m, input int cr, input int cnt);
        return m ? (cr >= 32) : (cnt >= 60);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 180; i++) hist[i] = 1'b0;
        ptr = 0; m_cnt = 0; m_zr = 0; m_cr = 0;
        m_alarm = 1'b0; m_decl = 1'b0; m_clr = 1'b0;
    endtask

    task automatic model_step(input bit b, input bit en, input bit m);
        m_decl = 1'b0;
        m_clr  = 1'b0;
        if (m != m_mode) begin
            model_clear();
        end else if (en) begin
            m_zr = b ? 0 : ((m_zr < 180) ? m_zr + 1 : m_zr);
            m_cr = (m_zr >= 4) ? 0 : ((m_cr < 32) ? m_cr + 1 : m_cr);
            m_cnt = m_cnt + int'(b) - int'(hist[ptr]);
            hist[ptr] = b;
            ptr = (ptr + 1) % 180;
            if (!m_alarm && raise_rule(m, m_zr)) begin
                m_alarm = 1'b1; m_decl = 1'b1;
            end else if (m_alarm && drop_rule(m, m_cr, m_cnt)) begin
                m_alarm = 1'b0; m_clr = 1'b1;
            end
        end
        m_mode = m;
    endtask

    task automatic check_out(input string tag);
        checks++;
        if ({los_alarm, los_declared, los_cleared} !== {m_alarm, m_decl, m_clr}) begin
            errors++;
            $display("FAIL %s: alarm/declared/cleared = %b%b%b expected %b%b%b",
                     tag, los_alarm, los_declared, los_cleared, m_alarm, m_decl, m_clr);
        end
    endtask

    task automatic step(input bit b, input bit en, input bit m, input string tag);
        @(negedge clk);
        rx_bit = b; bit_en = en; mode_e3 = m;
        @(posedge clk);
        model_step(b, en, m);
        #1;
        check_out(tag);
    endtask

    task automatic run(input int n, input bit b, input bit en, input bit m, input string tag);
        for (int i = 0; i < n; i++) step(b, en, m, tag);
    endtask

    task automatic expect_alarm(input bit want, input string tag);
        checks++;
        if (los_alarm !== want) begin
            errors++;
            $display("FAIL %s: alarm = %b expected %b", tag, los_alarm, want);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        int seed;
        int dens;
        bit m;
        seed = $urandom(32'h5EED_1234);

        // R1: reset state
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b1; mode_e3 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_clear(); m_mode = 1'b0;
        check_out("R1");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check_out("R1");

        // R2 and R8: 179 spaces, ignored marks, then the 180th space
        run(179, 1'b0, 1'b1, 1'b0, "R2");
        expect_alarm(1'b0, "R2");
        run(5, 1'b1, 1'b0, 1'b0, "R8");
        expect_alarm(1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R2 R6");
        expect_alarm(1'b1, "R2");
        step(1'b1, 1'b0, 1'b0, "R6 R8");

        // R3 and R7: 59 marks do not clear, the 60th does
        run(59, 1'b1, 1'b1, 1'b0, "R3");
        expect_alarm(1'b1, "R3");
        step(1'b1, 1'b1, 1'b0, "R3 R7");
        expect_alarm(1'b0, "R3");
        step(1'b0, 1'b1, 1'b0, "R7");

        // R3: sparse marks (1 in 4) never reach the density threshold
        run(180, 1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 100; i++) begin
            step(1'b1, 1'b1, 1'b0, "R3");
            run(3, 1'b0, 1'b1, 1'b0, "R3");
        end
        expect_alarm(1'b1, "R3");
        run(80, 1'b1, 1'b1, 1'b0, "R3 R7");
        expect_alarm(1'b0, "R3");

        // R9: alarm up in DS3, then switch to E3
        run(180, 1'b0, 1'b1, 1'b0, "R2");
        expect_alarm(1'b1, "R9");
        step(1'b0, 1'b1, 1'b1, "R9");
        expect_alarm(1'b0, "R9");

        // R4: counters were emptied; 31 spaces do not raise, 32nd does
        run(31, 1'b0, 1'b1, 1'b1, "R4 R9");
        expect_alarm(1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, "R4 R6");
        expect_alarm(1'b1, "R4");

        // R5: 20 clean bits, then four zeros restart the count
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, 1'b1, "R5");
            run(3, 1'b0, 1'b1, 1'b1, "R5");
        end
        run(4, 1'b0, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 1'b1, 1'b1, "R5");
            run(3, 1'b0, 1'b1, 1'b1, "R5");
        end
        run(3, 1'b1, 1'b1, 1'b1, "R5");
        expect_alarm(1'b1, "R5");
        step(1'b1, 1'b1, 1'b1, "R5 R7");
        expect_alarm(1'b0, "R5");

        // R9: switch back to DS3 clears the E3 alarm without a pulse
        run(32, 1'b0, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b0, "R9");
        expect_alarm(1'b0, "R9");

        // Random phases with varied mark density, enables and mode flips
        m = 1'b0;
        for (int ph = 0; ph < 24; ph++) begin
            dens = $urandom_range(0, 4);
            if ($urandom_range(0, 3) == 0) m = ~m;
            for (int i = 0; i < 400; i++) begin
                bit b;
                bit en;
                case (dens)
                    0: b = 1'b0;
                    1: b = ($urandom_range(0, 7) == 0);
                    2: b = ($urandom_range(0, 2) == 0);
                    3: b = ($urandom_range(0, 1) == 0);
                    default: b = ($urandom_range(0, 19) != 0);
                endcase
                en = ($urandom_range(0, 4) != 0);
                step(b, en, m, "R2 R3 R4 R5 R8");
            end
        end

        finish_run();
    end
endmodule